// File: doc/BRIEF.md
# External Interrupt Pending Aggregator

This block gathers 24 external interrupt request lines and turns them into six interrupt outputs for a central interrupt controller. Each line passes through a synchronizer. A rising edge on the synchronized line sets a sticky pending bit. A mask register gates the pending bits, and the resulting effective bits are mapped onto the outputs. Lines 0 to 3 each drive their own output. Lines 4 to 7 share one output, and lines 8 to 23 share another.

Software uses a small register interface with two locations. Through it, software reads the pending and mask registers, writes the mask, and acknowledges interrupts by writing ones to the pending location. Lines 0 to 3 are always enabled, because the mask register never holds a 1 in its lowest four bits.

Top module: `eint_aggregator`

## Requirements
- R1: After reset the mask register reads 0xFFFFF0, the pending register reads 0, and all six outputs are 0.
- R2: Each input passes through a two-flop synchronizer. The first clock edge that samples a line high, after that line was sampled low, sets the line's pending bit two edges later. A line held high does not set its bit again.
- R3: A pending bit stays 1 until software clears it.
- R4: A write to address 1 (pending) clears each pending bit whose written bit is 1. Pending bits whose written bit is 0 keep their value.
- R5: When a clear and a new rising edge reach the same pending bit in the same cycle, the bit ends up set.
- R6: A write to address 0 (mask) loads bits 23:4 from the written data and forces bits 3:0 to 0.
- R7: For each n in 0 to 3, output bit n equals pending[n] AND NOT mask[n]. It is registered, so it reflects the values held during the previous cycle.
- R8: Output bit 4 is the registered OR of effective bits 4 to 7. Output bit 5 is the registered OR of effective bits 8 to 23.
- R9: The read data shows the register selected by the address (0 = mask, 1 = pending). It follows the address with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extIrq | input | 24 | Asynchronous interrupt request lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 mask, 1 pending |
| regWrData | input | 24 | Write data |
| regRdData | output | 24 | Read data of the selected register |
| irqOut | output | 6 | Interrupt outputs to the controller |

## Verification
The bench aims first at a clear that lands in the same cycle as a new edge. A design that let the clear win would silently drop that interrupt. It also writes all ones to the mask. A design that failed to force bits 3:0 to 0 would then mask lines 0 to 3 and read back 0xFFFFFF. Random traffic holds lines high across clears, which exposes a design that sets pending on level instead of on edge, because such a design re-sets a bit right after it is cleared. The random traffic also moves single lines inside the two shared groups, which catches outputs that are ORed over the wrong bit range or are driven combinationally instead of one cycle late.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int unsigned ADDR_MASK = 0;
  localparam int unsigned ADDR_PEND = 1;

  typedef struct packed {
    logic maskWr;
    logic pendClr;
  } eintStrobes_t;
endpackage

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
(
  input  logic         regWrEn,
  input  logic         regAddr,
  output eintStrobes_t strobes
);
  always_comb begin
    strobes.maskWr  = regWrEn && (regAddr == 1'(ADDR_MASK));
    strobes.pendClr = regWrEn && (regAddr == 1'(ADDR_PEND));
  end
endmodule

// File: rtl/eint_datapath.sv
module eint_datapath
  import eint_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 24,
  parameter int unsigned NUM_DIRECT  = 4,
  parameter int unsigned MID_END     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_OUT    = NUM_DIRECT + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] extIrq,
  input  eintStrobes_t         strobes,
  input  logic                 regAddr,
  input  logic [NUM_LINES-1:0] wrData,
  output logic [NUM_LINES-1:0] rdData,
  output logic [NUM_OUT-1:0]   irqOut
);
  localparam logic [NUM_LINES-1:0] LOCKED_BITS = NUM_LINES'((1 << NUM_DIRECT) - 1);
  localparam logic [NUM_LINES-1:0] MASK_RST    = ~LOCKED_BITS;

  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] lastQ;
  logic [NUM_LINES-1:0] riseVec;
  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] mask;
  logic [NUM_LINES-1:0] effective;
  logic [NUM_OUT-1:0]   outNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= extIrq;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= '0;
    else       lastQ <= syncQ[SYNC_STAGES-1];
  end

  assign riseVec = syncQ[SYNC_STAGES-1] & ~lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else if (strobes.pendClr) begin
      pending <= (pending & ~wrData) | riseVec;
    end else begin
      pending <= pending | riseVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               mask <= MASK_RST;
    else if (strobes.maskWr) mask <= wrData & ~LOCKED_BITS;
  end

  assign effective = pending & ~mask;

  for (genvar d = 0; d < NUM_DIRECT; d++) begin : gDirect
    assign outNext[d] = effective[d];
  end
  assign outNext[NUM_DIRECT]   = |effective[MID_END-1:NUM_DIRECT];
  assign outNext[NUM_DIRECT+1] = |effective[NUM_LINES-1:MID_END];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= outNext;
  end

  assign rdData = (regAddr == 1'(ADDR_PEND)) ? pending : mask;

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pendClr |=> ((pending & $past(pending)) == $past(pending)));

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pendClr |=> ((pending & $past(wrData & ~riseVec)) == '0));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riseVec != '0) |=> ((pending & $past(riseVec)) == $past(riseVec)));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskWr |=> (mask == ($past(wrData) & ~LOCKED_BITS)));

  // R7
  direct_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut[NUM_DIRECT-1:0] ==
              $past(pending[NUM_DIRECT-1:0] & ~mask[NUM_DIRECT-1:0])));

  // R8
  group_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((irqOut[NUM_DIRECT] == $past(|(pending[MID_END-1:NUM_DIRECT] &
                                             ~mask[MID_END-1:NUM_DIRECT]))) &&
              (irqOut[NUM_DIRECT+1] == $past(|(pending[NUM_LINES-1:MID_END] &
                                               ~mask[NUM_LINES-1:MID_END])))));
endmodule

// File: rtl/eint_aggregator.sv
module eint_aggregator
  import eint_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [23:0] extIrq,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [23:0] regWrData,
  output logic [23:0] regRdData,
  output logic [5:0]  irqOut
);
  eintStrobes_t strobes;

  eint_ctrl uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  eint_datapath #(
    .NUM_LINES   (24),
    .NUM_DIRECT  (4),
    .MID_END     (8),
    .SYNC_STAGES (2)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .extIrq  (extIrq),
    .strobes (strobes),
    .regAddr (regAddr),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/tb_eint_aggregator.sv
module tb_eint_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] extIrq = '0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [23:0] regWrData = '0;
  logic [23:0] regRdData;
  logic [5:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] m1 = '0, m2 = '0, m3 = '0;
  logic [23:0] mPend = '0;
  logic [23:0] mMask = 24'hFFFFF0;
  logic [5:0]  mOut = '0;

  eint_aggregator dut (
    .clk       (clk),
    .rstN      (rstN),
    .extIrq    (extIrq),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  always #10 clk = ~clk;

  function automatic logic [5:0] groupOut(input logic [23:0] eff);
    return {|eff[23:8], |eff[7:4], eff[3:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  always @(posedge clk or negedge rstN) begin
    logic [23:0] rise;
    logic [23:0] nPend;
    if (!rstN) begin
      m1 = '0; m2 = '0; m3 = '0;
      mPend = '0; mMask = 24'hFFFFF0; mOut = '0;
    end else begin
      rise  = m2 & ~m3;
      nPend = mPend;
      if (regWrEn && regAddr) nPend = nPend & ~regWrData;
      nPend = nPend | rise;
      mOut  = groupOut(mPend & ~mMask);
      if (regWrEn && !regAddr) mMask = regWrData & 24'hFFFFF0;
      mPend = nPend;
      m3 = m2; m2 = m1; m1 = extIrq;
    end
  end

  // continuous comparison, well after inputs settle
  always @(negedge clk) begin
    #5;
    if (rstN && !done) begin
      check("R7", {26'd0, irqOut[3:0]}, {26'd0, mOut[3:0]});
      check("R8", {30'd0, irqOut[5:4]}, {30'd0, mOut[5:4]});
      check("R9", {8'd0, regRdData}, {8'd0, regAddr ? mPend : mMask});
    end
  end

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    regAddr = 1'b0;
    #1 check("R1", {8'd0, regRdData}, 32'h00FFFFF0);
    regAddr = 1'b1;
    #1 check("R1", {8'd0, regRdData}, 32'h0);
    check("R1", {26'd0, irqOut}, 32'h0);
    rstN = 1'b1;

    // R6: writing all ones leaves bits 3:0 at zero
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = 24'hFFFFFF;
    @(negedge clk);
    regWrEn = 1'b0;
    #1 check("R6", {8'd0, regRdData}, 32'h00FFFFF0);

    // unmask everything else
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = 24'h000000;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b1;

    // R2: edge on line 9 appears in pending two edges after first sample
    extIrq[9] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    #1 check("R2", {31'd0, regRdData[9]}, 32'd0);
    // R5: clear in the cycle the edge arrives, set wins
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 24'h000200;
    @(negedge clk);
    regWrEn = 1'b0;
    #1 check("R5", {31'd0, regRdData[9]}, 32'd1);
    @(negedge clk);
    #1 check("R8", {31'd0, irqOut[5]}, 32'd1);

    // R2/R4: clear while line still held high; no re-set
    regWrEn = 1'b1; regWrData = 24'h000200;
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (4) @(negedge clk);
    #1 check("R2", {31'd0, regRdData[9]}, 32'd0);
    check("R4", {26'd0, irqOut}, 32'd0);
    extIrq = '0;
    repeat (4) @(negedge clk);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      extIrq = extIrq ^ (24'($urandom) & 24'($urandom) & 24'($urandom));
      if (($urandom % 4) == 0) begin
        regWrEn   = 1'b1;
        regAddr   = 1'($urandom);
        regWrData = 24'($urandom);
        if (($urandom % 3) == 0) regWrData = regWrData & 24'($urandom);
      end else begin
        regWrEn = 1'b0;
        regAddr = 1'($urandom);
      end
    end
    @(negedge clk);
    regWrEn = 1'b0;
    regAddr = 1'b1;
    // R3: pending held with no clears
    repeat (3) @(negedge clk);
    #1 check("R3", {8'd0, regRdData}, {8'd0, mPend});
    // R4: clear only low half
    regWrEn = 1'b1; regWrData = 24'h000FFF;
    extIrq = extIrq;
    @(negedge clk);
    regWrEn = 1'b0;
    #1 check("R4", {8'd0, regRdData}, {8'd0, mPend});
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule